// File: doc/BRIEF.md
# Log Block Merge Classifier

This block keeps a page record for a set of data blocks in a hybrid-mapped flash translation layer. Each data block owns a single log block. Every update to a data block is placed, out of place, into the next unused page of that log block. Pages therefore land in strictly increasing physical order. For each logical block the record holds how many log pages are in use, whether every write so far hit the offset equal to its log position, and, for each page offset, the log page that holds the newest copy.

When a block is cleaned, the record selects one of three merges. A switch merge applies when the log holds the whole block in order. A partial merge applies when the log holds an in-order prefix. A full merge covers every other case. The block then issues the page-copy and block-erase commands that the chosen merge needs, over a valid/ready stream. Cleaning starts on an explicit request, or by itself as soon as a log block runs out of free pages. Commands name blocks by role (old data block, log block, freshly erased block) together with the logical block number. Physical placement is left to the mapping logic downstream.

Top module: `log_merge_unit`

## Requirements
- R1: After reset, wr_ready and clean_ready are high, cmd_valid and merge_done are low, merge_type is 0, and every record is empty.
- R2: An accepted write for block b goes into log page fill(b), which is then incremented. A full merge reports that page as cmd_src_page for the offset written.
- R3: A switch merge applies when the log holds all PAGES pages with page k at offset k. merge_type reads 1, and the only command is one erase (cmd_op=1) of the old data block (cmd_src=0).
- R4: The write that uses the last free page of a log block starts a merge of that block by itself. wr_ready and clean_ready are low in the next cycle, and commands begin the cycle after that.
- R5: A partial merge applies when 0 < fill < PAGES and every log page k holds offset k. merge_type reads 2. The commands are copies (cmd_op=0) from the data block (cmd_src=0) page k to the log block (cmd_dst=0) page k, for k = fill..PAGES-1 in ascending order, followed by one erase of the data block.
- R6: A full merge applies when the log is non-empty and not in order. merge_type reads 3. For each offset k = 0..PAGES-1 one copy goes to the fresh block (cmd_dst=1) page k. Its source is the log block (cmd_src=1) when k was written, and the data block page k otherwise. The copies are followed by an erase of the data block (cmd_src=0) and then an erase of the log block (cmd_src=1).
- R7: Writing an offset that is already in the log makes the newer log page the valid copy, and the block can then only take a full merge.
- R8: Cleaning an empty log gives merge_type 0 and a merge_done pulse, with no command issued.
- R9: While cmd_valid is high and cmd_ready is low, the command and all of its fields stay unchanged.
- R10: merge_done is high for exactly one cycle, in the cycle after the last erase is accepted. At the same edge the block's record is cleared.
- R11: While a merge runs, both wr_ready and clean_ready are low. In an idle cycle with clean_req high, wr_ready is low, so the clean request wins over a write.
- R12: Writes to one block leave the record and the merge of every other block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Page write offered |
| wr_ready | output | 1 | Page write can be taken |
| wr_blk | input | BW | Logical block of the write |
| wr_page | input | PW | Page offset of the write |
| clean_req | input | 1 | Clean request offered |
| clean_ready | output | 1 | Clean request can be taken |
| clean_blk | input | BW | Logical block to clean |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Command accepted by downstream |
| cmd_op | output | 1 | 0 copy, 1 erase |
| cmd_blk | output | BW | Logical block of the merge |
| cmd_src | output | 1 | Source role (copy) or erased role: 0 data, 1 log |
| cmd_src_page | output | PW | Source page of a copy |
| cmd_dst | output | 1 | Copy target: 0 log block, 1 fresh block |
| cmd_dst_page | output | PW | Target page of a copy |
| merge_type | output | 2 | 0 none, 1 switch, 2 partial, 3 full; held after a merge |
| merge_done | output | 1 | One-cycle pulse at merge end |

## Verification
The bench builds the block with PAGES=8 and NBLK=3. At that size a log block fills within a few writes, so the automatic start, the switch case and a full merge reached by filling the log through a rewrite can all be exercised in a short run. It also gives three blocks, enough to leave writes pending on a neighbour while a merge runs. A periodic cmd_ready pattern holds commands under backpressure, and a write raised in the same cycle as a clean request exercises the priority between them.

// File: rtl/lmu_pkg.sv
package lmu_pkg;

  typedef enum logic [1:0] {
    MT_NONE    = 2'd0,
    MT_SWITCH  = 2'd1,
    MT_PARTIAL = 2'd2,
    MT_FULL    = 2'd3
  } merge_t;

  localparam logic OP_COPY  = 1'b0;
  localparam logic OP_ERASE = 1'b1;
  localparam logic ROLE_DATA = 1'b0;
  localparam logic ROLE_LOG  = 1'b1;
  localparam logic DST_LOG   = 1'b0;
  localparam logic DST_FRESH = 1'b1;

  // Merge selection from the fill count and the in-order flag.
  function automatic merge_t classify(input int unsigned fill, input logic inorder,
                                      input int unsigned pages);
    if (fill == 0)          return MT_NONE;
    else if (!inorder)      return MT_FULL;
    else if (fill == pages) return MT_SWITCH;
    else                    return MT_PARTIAL;
  endfunction

  // First page offset to copy; pages means no copy phase.
  function automatic int unsigned first_copy(input merge_t t, input int unsigned fill,
                                             input int unsigned pages);
    case (t)
      MT_PARTIAL: return fill;
      MT_FULL:    return 0;
      default:    return pages;
    endcase
  endfunction

  // Number of erase commands that close a merge.
  function automatic int unsigned erase_total(input merge_t t);
    case (t)
      MT_FULL: return 2;
      MT_NONE: return 0;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/lmu_record.sv
module lmu_record #(
  parameter int NBLK  = 4,
  parameter int PAGES = 256,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(PAGES + 1),
  localparam int AW = $clog2(NBLK * PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic [PW-1:0] wr_page,
  output logic          wr_fills,
  input  logic          clr_en,
  input  logic [BW-1:0] clr_blk,
  input  logic [BW-1:0] q_blk,
  output logic [CW-1:0] q_fill,
  output logic          q_inorder,
  input  logic [BW-1:0] lk_blk,
  input  logic [PW-1:0] lk_page,
  output logic          lk_hit,
  output logic [PW-1:0] lk_logpage
);

  logic [CW-1:0]    fill_q    [NBLK];
  logic             inorder_q [NBLK];
  logic [PAGES-1:0] vld_q     [NBLK];
  logic [PW-1:0]    lpage_q   [NBLK*PAGES];

  logic [AW-1:0] wr_addr, lk_addr;
  assign wr_addr = AW'(int'(wr_blk) * PAGES + int'(wr_page));
  assign lk_addr = AW'(int'(lk_blk) * PAGES + int'(lk_page));

  assign wr_fills   = (fill_q[wr_blk] == CW'(PAGES - 1));
  assign q_fill     = fill_q[q_blk];
  assign q_inorder  = inorder_q[q_blk];
  assign lk_hit     = vld_q[lk_blk][lk_page];
  assign lk_logpage = lpage_q[lk_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        fill_q[b]    <= '0;
        inorder_q[b] <= 1'b1;
        vld_q[b]     <= '0;
      end
    end else begin
      for (int b = 0; b < NBLK; b++) begin
        if (clr_en && clr_blk == BW'(b)) begin
          fill_q[b]    <= '0;
          inorder_q[b] <= 1'b1;
          vld_q[b]     <= '0;
        end else if (wr_en && wr_blk == BW'(b)) begin
          fill_q[b]           <= fill_q[b] + 1'b1;
          inorder_q[b]        <= inorder_q[b] && (CW'(wr_page) == fill_q[b]);
          vld_q[b][wr_page]   <= 1'b1;
        end
      end
    end
  end

  // Newest copy of an offset always points at the page just written.
  always_ff @(posedge clk) begin
    if (wr_en) lpage_q[wr_addr] <= fill_q[wr_blk][PW-1:0];
  end

  // R2
  wr_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (fill_q[wr_blk] < CW'(PAGES)));

  for (genvar g = 0; g < NBLK; g++) begin : g_fill_chk
    // R4
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q[g] <= CW'(PAGES));
  end

endmodule

// File: rtl/lmu_seq.sv
module lmu_seq
  import lmu_pkg::*;
#(
  parameter int PAGES = 256,
  parameter int BW    = 2,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] start_blk,
  input  merge_t        start_type,
  input  logic [CW-1:0] start_fill,
  output logic          busy,
  output logic [PW-1:0] lk_page,
  input  logic          lk_hit,
  input  logic [PW-1:0] lk_logpage,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_op,
  output logic [BW-1:0] cmd_blk,
  output logic          cmd_src,
  output logic [PW-1:0] cmd_src_page,
  output logic          cmd_dst,
  output logic [PW-1:0] cmd_dst_page,
  output logic          fin,
  output logic          done,
  output merge_t        mtype
);

  logic          busy_q, copying_q, ers_q, done_q;
  logic [BW-1:0] blk_q;
  merge_t        type_q;
  logic [CW-1:0] idx_q;
  logic          fire, last_copy, last_erase;
  int unsigned   fc;

  assign fire       = busy_q && cmd_ready;
  assign last_copy  = (idx_q == CW'(PAGES - 1));
  assign last_erase = (erase_total(type_q) == (ers_q ? 2 : 1));
  assign fin        = fire && !copying_q && last_erase;
  assign fc         = first_copy(start_type, int'(start_fill), PAGES);

  assign busy      = busy_q;
  assign done      = done_q;
  assign mtype     = type_q;
  assign cmd_valid = busy_q;
  assign cmd_blk   = blk_q;
  assign lk_page   = idx_q[PW-1:0];

  always_comb begin
    cmd_op       = OP_ERASE;
    cmd_src      = ers_q ? ROLE_LOG : ROLE_DATA;
    cmd_src_page = '0;
    cmd_dst      = DST_LOG;
    cmd_dst_page = '0;
    if (copying_q) begin
      cmd_op       = OP_COPY;
      cmd_dst_page = idx_q[PW-1:0];
      if (type_q == MT_FULL) begin
        cmd_dst      = DST_FRESH;
        cmd_src      = lk_hit ? ROLE_LOG : ROLE_DATA;
        cmd_src_page = lk_hit ? lk_logpage : idx_q[PW-1:0];
      end else begin
        cmd_src      = ROLE_DATA;
        cmd_src_page = idx_q[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      copying_q <= 1'b0;
      ers_q     <= 1'b0;
      done_q    <= 1'b0;
      blk_q     <= '0;
      type_q    <= MT_NONE;
      idx_q     <= '0;
    end else begin
      done_q <= fin || (start && !busy_q && start_type == MT_NONE);
      if (start && !busy_q) begin
        blk_q     <= start_blk;
        type_q    <= start_type;
        ers_q     <= 1'b0;
        idx_q     <= CW'(fc);
        copying_q <= (fc < PAGES);
        busy_q    <= (start_type != MT_NONE);
      end else if (fire) begin
        if (copying_q) begin
          if (last_copy) copying_q <= 1'b0;
          else           idx_q     <= idx_q + 1'b1;
        end else if (last_erase) begin
          busy_q <= 1'b0;
        end else begin
          ers_q <= 1'b1;
        end
      end
    end
  end

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid &&
      $stable({cmd_op, cmd_blk, cmd_src, cmd_src_page, cmd_dst, cmd_dst_page})));

  // R3
  switch_erase_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && mtype == MT_SWITCH) |-> (cmd_op == OP_ERASE));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  fin_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done && !cmd_valid));

endmodule

// File: rtl/log_merge_unit.sv
module log_merge_unit
  import lmu_pkg::*;
#(
  parameter int NBLK  = 4,
  parameter int PAGES = 256,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [BW-1:0] wr_blk,
  input  logic [PW-1:0] wr_page,
  input  logic          clean_req,
  output logic          clean_ready,
  input  logic [BW-1:0] clean_blk,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_op,
  output logic [BW-1:0] cmd_blk,
  output logic          cmd_src,
  output logic [PW-1:0] cmd_src_page,
  output logic          cmd_dst,
  output logic [PW-1:0] cmd_dst_page,
  output logic [1:0]    merge_type,
  output logic          merge_done
);

  logic          busy, fin, done, auto_q, wr_fire, clean_fire, start, wr_fills;
  logic [BW-1:0] auto_blk_q, start_blk;
  logic [CW-1:0] q_fill;
  logic          q_inorder, lk_hit;
  logic [PW-1:0] lk_page, lk_logpage;
  merge_t        start_type, mtype;

  assign clean_ready = !busy && !auto_q;
  assign wr_ready    = clean_ready && !clean_req;
  assign wr_fire     = wr_valid && wr_ready;
  assign clean_fire  = clean_req && clean_ready;
  assign start       = auto_q || clean_fire;
  assign start_blk   = auto_q ? auto_blk_q : clean_blk;
  assign start_type  = classify(int'(q_fill), q_inorder, PAGES);
  assign merge_type  = mtype;
  assign merge_done  = done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_q     <= 1'b0;
      auto_blk_q <= '0;
    end else begin
      auto_q     <= wr_fire && wr_fills;
      auto_blk_q <= wr_blk;
    end
  end

  lmu_record #(.NBLK(NBLK), .PAGES(PAGES)) u_record (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_blk(wr_blk), .wr_page(wr_page), .wr_fills(wr_fills),
    .clr_en(fin), .clr_blk(cmd_blk),
    .q_blk(start_blk), .q_fill(q_fill), .q_inorder(q_inorder),
    .lk_blk(cmd_blk), .lk_page(lk_page), .lk_hit(lk_hit), .lk_logpage(lk_logpage)
  );

  lmu_seq #(.PAGES(PAGES), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_blk(start_blk), .start_type(start_type), .start_fill(q_fill),
    .busy(busy), .lk_page(lk_page), .lk_hit(lk_hit), .lk_logpage(lk_logpage),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .cmd_src(cmd_src), .cmd_src_page(cmd_src_page), .cmd_dst(cmd_dst),
    .cmd_dst_page(cmd_dst_page), .fin(fin), .done(done), .mtype(mtype)
  );

  // R4
  auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q |=> cmd_valid);

  // R11
  clean_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clean_req |-> !wr_ready);

endmodule

// File: tb/log_merge_unit_tb.sv
module log_merge_unit_tb;
  localparam int NB = 3;
  localparam int PG = 8;
  localparam int BW = 2;
  localparam int PW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, clean_req = 0, cmd_ready = 1;
  logic [BW-1:0] wr_blk = 0, clean_blk = 0;
  logic [PW-1:0] wr_page = 0;
  logic wr_ready, clean_ready, cmd_valid, cmd_op, cmd_src, cmd_dst, merge_done;
  logic [BW-1:0] cmd_blk;
  logic [PW-1:0] cmd_src_page, cmd_dst_page;
  logic [1:0] merge_type;

  always #(CLK_PERIOD/2) clk = ~clk;

  log_merge_unit #(.NBLK(NB), .PAGES(PG)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_blk(wr_blk),
    .wr_page(wr_page), .clean_req(clean_req), .clean_ready(clean_ready),
    .clean_blk(clean_blk), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .cmd_src(cmd_src), .cmd_src_page(cmd_src_page), .cmd_dst(cmd_dst),
    .cmd_dst_page(cmd_dst_page), .merge_type(merge_type), .merge_done(merge_done));

  int nchk = 0, nfail = 0;
  bit bp = 0;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int enc(int op, int b, int s, int sp, int d, int dp);
    return (op << 24) | (b << 16) | (s << 15) | (sp << 8) | (d << 7) | dp;
  endfunction

  // Reference model state
  int fillm[NB];
  bit ino[NB];
  int mapm[NB][PG];
  int q[$];
  bit mbusy = 0, apend = 0, dexp = 0;
  int ablk = 0, mblk = 0, texp = 0;

  function automatic string ttag(int t);
    case (t) 1: return "R3"; 2: return "R5"; 3: return "R6"; default: return "R8"; endcase
  endfunction

  task automatic clear_blk(int b);
    fillm[b] = 0; ino[b] = 1;
    for (int k = 0; k < PG; k++) mapm[b][k] = -1;
  endtask

  task automatic m_start(int b);
    int t;
    if (fillm[b] == 0) t = 0; else if (!ino[b]) t = 3; else if (fillm[b] == PG) t = 1; else t = 2;
    texp = t; mblk = b;
    if (t == 0) begin dexp = 1; return; end
    mbusy = 1;
    if (t == 2) for (int k = fillm[b]; k < PG; k++) q.push_back(enc(0, b, 0, k, 0, k));
    if (t == 3)
      for (int k = 0; k < PG; k++)
        if (mapm[b][k] >= 0) q.push_back(enc(0, b, 1, mapm[b][k], 1, k));
        else q.push_back(enc(0, b, 0, k, 1, k));
    q.push_back(enc(1, b, 0, 0, 0, 0));
    if (t == 3) q.push_back(enc(1, b, 1, 0, 0, 0));
  endtask

  initial for (int b = 0; b < NB; b++) clear_blk(b);

  always @(negedge clk) begin
    if (rst_n) begin
      bit dn;
      dn = 0;
      chk("R11", wr_ready, !mbusy && !apend && !clean_req);
      chk("R11", clean_ready, !mbusy && !apend);
      chk("R9", cmd_valid, q.size() > 0);
      if (cmd_valid && q.size() > 0)
        chk(ttag(texp), enc(cmd_op, cmd_blk, cmd_src, cmd_src_page, cmd_dst, cmd_dst_page), q[0]);
      chk("R10", merge_done, dexp);
      chk(ttag(texp), merge_type, texp);
      dexp = 0;
      if (mbusy) begin
        if (cmd_valid && cmd_ready && q.size() > 0) begin
          void'(q.pop_front());
          if (q.size() == 0) begin mbusy = 0; dn = 1; clear_blk(mblk); end
        end
      end else if (apend) begin
        apend = 0; m_start(ablk);
      end else if (clean_req) begin
        m_start(int'(clean_blk));
      end else if (wr_valid) begin
        int b;
        b = int'(wr_blk);
        mapm[b][wr_page] = fillm[b];
        ino[b] = ino[b] && (int'(wr_page) == fillm[b]);
        fillm[b]++;
        if (fillm[b] == PG) begin apend = 1; ablk = b; end
      end
      if (dn) dexp = 1;
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      cmd_ready = bp ? (cyc % 3 != 1) : 1'b1;
    end
  end

  task automatic do_wr(int b, int p);
    wr_valid = 1; wr_blk = BW'(b); wr_page = PW'(p);
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic do_clean(int b);
    clean_req = 1; clean_blk = BW'(b);
    do @(negedge clk); while (!clean_ready);
    @(posedge clk); #1 clean_req = 0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    do @(negedge clk); while (!clean_ready);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: idle outputs right after reset
    chk("R1", wr_ready, 1); chk("R1", cmd_valid, 0); chk("R1", merge_type, 0);
    @(posedge clk); #1;
    // R1 R8: empty record cleans to type none without commands
    do_clean(0); settle();
    // R3 R4: in-order fill of block 0 triggers a switch merge
    for (int k = 0; k < PG; k++) do_wr(0, k);
    settle();
    // R12 R5 R9: prefix on block 1, neighbour write on block 2, backpressure
    do_wr(1, 0); do_wr(2, 5); do_wr(1, 1); do_wr(1, 2);
    bp = 1;
    do_clean(1); settle();
    // R2 R6 R7: block 2 rewrites offset 5, full merge uses the newest copy
    do_wr(2, 2); do_wr(2, 5);
    do_clean(2); settle();
    // R10: block 1 record cleared after its merge
    do_clean(1); settle();
    // R7 R11: rewrite on block 0, then clean and write raised together
    do_wr(0, 0); do_wr(0, 1); do_wr(0, 0);
    fork
      do_clean(0);
      do_wr(0, 4);
    join
    settle();
    // R4 R6: block 1 filled through a duplicate starts a full merge itself
    bp = 0;
    do_wr(1, 0); do_wr(1, 0);
    for (int k = 1; k < PG - 1; k++) do_wr(1, k);
    settle();
    // R2 R6: block 0 holds a single out-of-order page
    do_clean(0); settle();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule